// File: doc/BRIEF.md
# SPI Slave Byte Transceiver

This block is the slave end of a four-wire serial link. It exchanges one byte at a time with an external master: while the master clocks a byte in on the data-in line, the block clocks the contents of its transmit register out on the data-out line. The serial clock, data-in and select lines are brought into the system clock domain through synchronizer chains. All decisions are taken on edges detected in that domain, so the system clock must run at least four times faster than the serial clock.

The CPU side configures the block with an enable bit, a clock-polarity bit and a clock-phase bit. It loads the transmit register through a write strobe and takes each received byte from a holding register. A byte-complete flag tells the CPU that a received byte is waiting. A write-collision flag records a transmit load that was refused because a byte was in flight. A read strobe takes the received byte and clears both flags.

The two phase settings frame bytes differently. With phase 0, each byte needs its own falling edge of select, and the first data bit is already on the data-out line before any clock edge. With phase 1, the first clock edge after selection opens the byte, and select may stay low across any number of bytes. The data-out line is driven only while the block is enabled and selected; otherwise an output-enable signal releases it.

Top module: `spi_byte_slave`

## Requirements
- R1: A byte is 8 serial clock cycles. Bits travel most significant bit first in both directions. After the 8th capture, `rx_data` holds the byte seen on `spi_mosi` and `rx_done` is 1.
- R2: With `cfg_cpha`=0, data is captured on the leading serial clock edge. The most significant bit of the transmit register appears on `spi_miso` after select falls and before the first clock edge.
- R3: With `cfg_cpha`=0, one falling edge of `spi_ss_n` frames exactly one byte. Further clock edges while select stays low are ignored: `rx_done` and `rx_data` stay unchanged until select rises and falls again.
- R4: With `cfg_cpha`=1, the first leading edge after selection starts the byte and captures nothing. Data is captured on trailing edges. Consecutive bytes may be exchanged with `spi_ss_n` held low, each sending the transmit register as it stands when its first edge arrives.
- R5: A `tx_wr` while a byte is in progress is ignored and sets `wr_col`. The byte after it still sends the earlier transmit value.
- R6: `rx_rd` clears `rx_done` and `wr_col`. If a byte completes in the same cycle as `rx_rd`, `rx_done` ends that cycle set.
- R7: If `spi_ss_n` rises before the 8th capture, the partial byte is dropped. `rx_done` is not set, `rx_data` is unchanged, and the next full byte is received correctly.
- R8: `spi_miso_oe` is 1 only while `cfg_en`=1 and the synchronized select is low. It is 0 when select is high or the block is disabled.
- R9: `sck_idle_lvl` equals `cfg_cpol` while `cfg_en`=1, and is 1 while `cfg_en`=0.
- R10: After reset, `rx_done`=0, `wr_col`=0, `spi_miso_oe`=0 and `rx_data`=0.
- R11: `cfg_cpol`=0 means the serial clock idles low, so the leading edge is rising. `cfg_cpol`=1 means it idles high, so the leading edge is falling. All four polarity and phase combinations exchange bytes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Capture on leading (0) or trailing (1) edge |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | 8 | Transmit register write data |
| rx_rd | input | 1 | Received byte read strobe |
| rx_data | output | 8 | Last complete received byte |
| rx_done | output | 1 | Byte-complete flag |
| wr_col | output | 1 | Write-collision flag |
| sck_idle_lvl | output | 1 | Reported serial clock idle level |
| spi_sck | input | 1 | Serial clock from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
Two CPU-side events can land in the same system clock cycle: the completion of a byte, which sets `rx_done`, and a read strobe, which clears it. The bench holds `rx_rd` high through the whole last bit of a byte, so the completion is certain to coincide with a read. It counts the cycles in which `rx_done` is seen high and expects exactly one, together with the correct `rx_data`. A second overlap, a transmit load arriving while a byte is in flight, is provoked by writing from a parallel thread in the middle of the byte. It is judged by `wr_col` and by the value the master receives on the next byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    // Events decoded from the synchronized serial lines, one system cycle wide.
    typedef struct packed {
        logic lead;     // clock edge leaving the idle level
        logic trail;    // clock edge returning to the idle level
        logic ss_fall;  // select asserted
        logic ss_low;   // select currently asserted
        logic mosi;     // synchronized data-in
    } spi_evt_t;

    localparam int unsigned LINE_CNT = 3;  // sck, mosi, ss_n

endpackage

// File: rtl/spi_slv_front.sv
module spi_slv_front
    import spi_slv_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpol,
    input  logic     sck,
    input  logic     mosi,
    input  logic     ss_n,
    output spi_evt_t evt
);
    localparam int unsigned LW = LINE_CNT;
    localparam logic [LW-1:0] LINE_RST = {1'b1, 1'b0, 1'b0}; // ss_n idles high

    logic [LW-1:0] raw;
    logic [STAGES-1:0][LW-1:0] chain_q, chain_d;

    assign raw = {ss_n, mosi, sck};

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = raw;
        end else begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], raw};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{LINE_RST}};
        else        chain_q <= chain_d;
    end

    typedef struct packed {
        logic sck_prev;
        logic ss_prev;
    } front_t;

    front_t st_q, st_d;
    logic   sck_s, ss_s;

    assign sck_s = chain_q[STAGES-1][0];
    assign ss_s  = chain_q[STAGES-1][2];

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.ss_prev  = ss_s;
        evt.mosi      = chain_q[STAGES-1][1];
        evt.ss_low    = !ss_s;
        evt.ss_fall   = st_q.ss_prev && !ss_s;
        // Leading edge leaves the idle level chosen by cpol.
        evt.lead      = (st_q.sck_prev == cpol) && (sck_s != cpol);
        evt.trail     = (st_q.sck_prev != cpol) && (sck_s == cpol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sck_prev: 1'b0, ss_prev: 1'b1};
        else        st_q <= st_d;
    end

    // R11: an edge is never both leading and trailing
    assert_edge_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.lead && evt.trail));

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cpha,
    input  spi_evt_t     evt,
    input  logic [W-1:0] tx_reg,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         miso,
    output logic         oe
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     rx_sh;
        logic [W-1:0]     tx_sh;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             oe;
        logic             done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!en) begin
            d = '0;
        end else if (!evt.ss_low) begin
            // deselect: drop any partial byte
            d.busy = 1'b0;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else begin
            d.oe = 1'b1;
            if (!cpha) begin
                if (evt.ss_fall) begin
                    d.tx_sh = tx_reg;
                    d.cnt   = '0;
                    d.busy  = 1'b1;
                end else if (q.busy) begin
                    if (evt.lead) begin
                        d.rx_sh = {q.rx_sh[W-2:0], evt.mosi};
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == LAST) begin
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end
                    end else if (evt.trail) begin
                        d.tx_sh = {q.tx_sh[W-2:0], 1'b0};
                    end
                end
            end else begin
                if (evt.lead) begin
                    if (!q.busy) begin
                        d.busy  = 1'b1;
                        d.cnt   = '0;
                        d.tx_sh = tx_reg;
                    end else begin
                        d.tx_sh = {q.tx_sh[W-2:0], 1'b0};
                    end
                end else if (evt.trail && q.busy) begin
                    d.rx_sh = {q.rx_sh[W-2:0], evt.mosi};
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_byte = q.rx_sh;
    assign miso    = q.tx_sh[W-1];
    assign oe      = q.oe;

    // R1: bit counter never passes the byte length
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(W));
    // R8: disabling releases the data-out line on the next cycle
    assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !oe);
    // R4: a completed byte leaves the engine idle
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: deselect aborts an open byte without completion
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !evt.ss_low) |=> (!busy && !done));

endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_wdata,
    input  logic         rx_rd,
    input  logic         busy,
    input  logic         byte_done,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] tx_reg,
    output logic [W-1:0] rx_data,
    output logic         rx_done,
    output logic         wr_col
);
    typedef struct packed {
        logic [W-1:0] tx;
        logic [W-1:0] rx;
        logic         done;
        logic         col;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (rx_rd) begin
            d.done = 1'b0;
            d.col  = 1'b0;
        end
        if (tx_wr) begin
            if (busy) d.col = 1'b1;
            else      d.tx  = tx_wdata;
        end
        // completion after the clear: a coincident set wins
        if (byte_done) begin
            d.rx   = byte_in;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_reg  = q.tx;
    assign rx_data = q.rx;
    assign rx_done = q.done;
    assign wr_col  = q.col;

    // R5: a load during a byte raises the collision flag
    assert_col_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> wr_col);
    // R5: a refused load leaves the transmit register untouched
    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> $stable(tx_reg));
    // R6: completion sets the flag even against a read
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> rx_done);
    // R6: read without completion clears the flag
    assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !byte_done) |=> !rx_done);

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spi_slv_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_cpol,
    input  logic         cfg_cpha,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_wdata,
    input  logic         rx_rd,
    output logic [W-1:0] rx_data,
    output logic         rx_done,
    output logic         wr_col,
    output logic         sck_idle_lvl,
    input  logic         spi_sck,
    input  logic         spi_mosi,
    input  logic         spi_ss_n,
    output logic         spi_miso,
    output logic         spi_miso_oe
);
    spi_evt_t     evt;
    logic         busy, byte_done;
    logic [W-1:0] byte_in, tx_reg;

    spi_slv_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk  (clk),
        .rst_n(rst_n),
        .cpol (cfg_cpol),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .ss_n (spi_ss_n),
        .evt  (evt)
    );

    spi_slv_shift #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_en),
        .cpha   (cfg_cpha),
        .evt    (evt),
        .tx_reg (tx_reg),
        .busy   (busy),
        .done   (byte_done),
        .rx_byte(byte_in),
        .miso   (spi_miso),
        .oe     (spi_miso_oe)
    );

    spi_slv_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_wr    (tx_wr),
        .tx_wdata (tx_wdata),
        .rx_rd    (rx_rd),
        .busy     (busy),
        .byte_done(byte_done),
        .byte_in  (byte_in),
        .tx_reg   (tx_reg),
        .rx_data  (rx_data),
        .rx_done  (rx_done),
        .wr_col   (wr_col)
    );

    assign sck_idle_lvl = cfg_en ? cfg_cpol : 1'b1;

    // R2: with leading-edge capture a byte opens only on a select fall
    assert_open_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_cpha && !busy && !evt.ss_fall) |=> !busy);

endmodule

// File: tb/sim_spi_byte_slave.sv
module sim_spi_byte_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic [7:0] rx_data;
    logic       rx_done, wr_col, sck_idle_lvl;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;
    logic       spi_miso, spi_miso_oe;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;
    int hi_cnt = 0;

    always #4 clk = ~clk;  // 125 MHz

    spi_byte_slave u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_done(rx_done), .wr_col(wr_col),
        .sck_idle_lvl(sck_idle_lvl), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_ss_n(spi_ss_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    always @(negedge clk) if (mon_en && rx_done) hi_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        tx_wdata = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    task automatic cpu_read(output logic [7:0] v);
        v = rx_data; rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    endtask

    task automatic set_mode(input bit pol, input bit pha);
        spi_ss_n = 1'b1; cfg_cpol = pol; cfg_cpha = pha; spi_sck = pol;
        tick(8);
    endtask

    // Master side: nbits clock cycles, select left low when keep is set.
    task automatic xfer(input logic [7:0] mo, input int nbits, input bit keep,
                        output logic [7:0] mi);
        mi = 8'h00;
        if (spi_ss_n) begin spi_ss_n = 1'b0; tick(8); end
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                spi_mosi = mo[7-i]; tick(8);
                mi[7-i] = spi_miso_oe ? spi_miso : 1'bx;
                spi_sck = ~cfg_cpol; tick(8);
                spi_sck = cfg_cpol;
            end else begin
                spi_sck = ~cfg_cpol; spi_mosi = mo[7-i]; tick(8);
                mi[7-i] = spi_miso_oe ? spi_miso : 1'bx;
                spi_sck = cfg_cpol; tick(8);
            end
        end
        tick(10);
        if (!keep) begin spi_ss_n = 1'b1; tick(8); end
    endtask

    initial begin
        logic [7:0] got, rd, mo, tv, keep_rx;
        tick(3); rst_n = 1'b1; tick(2);
        // R10: reset state
        chk(rx_done == 1'b0, "R10 rx_done", rx_done, 0);
        chk(wr_col == 1'b0, "R10 wr_col", wr_col, 0);
        chk(spi_miso_oe == 1'b0, "R10 oe", spi_miso_oe, 0);
        chk(rx_data == 8'h00, "R10 rx_data", rx_data, 0);
        // R9: idle level report
        chk(sck_idle_lvl == 1'b1, "R9 disabled", sck_idle_lvl, 1);
        cfg_en = 1'b1; cfg_cpol = 1'b0; tick(1);
        chk(sck_idle_lvl == 1'b0, "R9 cpol0", sck_idle_lvl, 0);
        cfg_cpol = 1'b1; tick(1);
        chk(sck_idle_lvl == 1'b1, "R9 cpol1", sck_idle_lvl, 1);
        cfg_en = 1'b0; cfg_cpol = 1'b0; tick(1);
        chk(sck_idle_lvl == 1'b1, "R9 disabled cpol0", sck_idle_lvl, 1);
        cfg_en = 1'b1;

        // R1 R2 R4 R11: sweep all modes and data patterns
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            for (int k = 0; k < 6; k++) begin
                mo = 8'((k * 8'h47 + m * 8'h1d) ^ (k[0] ? 8'hff : 8'h00));
                tv = 8'((mo * 3 + 1) ^ 8'h5a);
                cpu_write(tv);
                xfer(mo, 8, 1'b0, got);
                chk(got === tv, m[0] ? "R4 R11 miso" : "R2 R11 miso", got, tv);
                chk(rx_done == 1'b1, "R1 done set", rx_done, 1);
                chk(rx_data == mo, "R1 rx_data", rx_data, mo);
                cpu_read(rd);
                chk(rx_done == 1'b0, "R6 read clears", rx_done, 0);
            end
        end

        // R4: back-to-back bytes with select held low
        set_mode(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            tv = 8'(8'h90 + k * 7); mo = 8'(8'h21 * (k + 1));
            cpu_write(tv);
            xfer(mo, 8, (k < 2), got);
            chk(got === tv, "R4 held-select miso", got, tv);
            chk(rx_data == mo, "R4 held-select rx", rx_data, mo);
            cpu_read(rd);
        end

        // R3: extra clocks after a phase-0 byte are ignored
        set_mode(1'b1, 1'b0);
        cpu_write(8'h66);
        xfer(8'hb4, 8, 1'b1, got);
        cpu_read(rd);
        for (int i = 0; i < 8; i++) begin
            spi_mosi = ~spi_mosi; spi_sck = ~cfg_cpol; tick(8); spi_sck = cfg_cpol; tick(8);
        end
        tick(10);
        chk(rx_done == 1'b0, "R3 no second byte", rx_done, 0);
        chk(rx_data == 8'hb4, "R3 rx held", rx_data, 8'hb4);
        spi_ss_n = 1'b1; tick(8);

        // R7: abort mid-byte in both phases
        for (int p = 0; p < 2; p++) begin
            set_mode(1'b0, p[0]);
            keep_rx = rx_data;
            xfer(8'hff, 4, 1'b0, got);
            chk(rx_done == 1'b0, "R7 no flag", rx_done, 0);
            chk(rx_data == keep_rx, "R7 rx unchanged", rx_data, keep_rx);
            cpu_write(8'h3e);
            xfer(8'h0f, 8, 1'b0, got);
            chk(rx_data == 8'h0f, "R7 next byte", rx_data, 8'h0f);
            chk(got === 8'h3e, "R7 next miso", got, 8'h3e);
            cpu_read(rd);
        end

        // R5: collision during a byte
        set_mode(1'b0, 1'b0);
        cpu_write(8'h3c);
        fork
            xfer(8'h77, 8, 1'b0, got);
            begin tick(60); cpu_write(8'hc3); end
        join
        chk(wr_col == 1'b1, "R5 wr_col set", wr_col, 1);
        chk(got === 8'h3c, "R5 byte kept", got, 8'h3c);
        xfer(8'h11, 8, 1'b0, got);
        chk(got === 8'h3c, "R5 write ignored", got, 8'h3c);
        cpu_read(rd);
        chk(wr_col == 1'b0, "R6 read clears wr_col", wr_col, 0);

        // R6: read strobe coincident with completion
        rx_rd = 1'b1; hi_cnt = 0; mon_en = 1'b1;
        xfer(8'hd2, 8, 1'b0, got);
        mon_en = 1'b0; rx_rd = 1'b0;
        chk(hi_cnt == 1, "R6 set wins once", hi_cnt, 1);
        chk(rx_data == 8'hd2, "R6 rx_data", rx_data, 8'hd2);

        // R8: output enable
        set_mode(1'b0, 1'b1);
        chk(spi_miso_oe == 1'b0, "R8 ss high", spi_miso_oe, 0);
        spi_ss_n = 1'b0; tick(6);
        chk(spi_miso_oe == 1'b1, "R8 selected", spi_miso_oe, 1);
        cfg_en = 1'b0; tick(2);
        chk(spi_miso_oe == 1'b0, "R8 disabled", spi_miso_oe, 0);
        cfg_en = 1'b1; spi_ss_n = 1'b1; tick(6);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule